// File: doc/BRIEF.md
# I2C Target Register Map

This block is a bus target on a two-wire serial bus with a fixed 7-bit address. It oversamples the serial clock and data lines with the system clock, recognises START, repeated START and STOP, and walks a byte-level protocol. A write carries a register pointer and then one data byte. A read sets the pointer with a write, issues a repeated START, and then receives the register contents. Eight 8-bit registers sit behind the pointer. Two command bytes are held until they are overwritten. Two measurement bytes come straight from parallel sensor inputs and cannot be written. Four bytes form a 16-bit low limit and a 16-bit high limit.

The sensor side is plain parallel wiring. The measurement inputs are sampled whenever a read needs them, and the command and limit outputs are register values. No stream moves across the boundary, so the block has no valid/ready handshake and applies no back-pressure. The serial bus cannot be stalled because the block never holds the clock low. The data line is open-drain: when `sda_oe` is high the line is pulled low, and otherwise it is released.

Top module: `i2c_regmap_target`

## Requirements
- R1: The block responds only to address 7'b1000100. Only the upper seven bits of the first byte after START are compared. Bit 0 selects read (1) or write (0). An address byte with any other 7-bit value is left unacknowledged.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A byte sent without a preceding START gets no acknowledge.
- R3: The block pulls SDA low (`sda_oe`=1) through the ninth clock of the matching address byte, of the pointer byte (any value) and of the first data byte of a write.
- R4: A write sends address+W, pointer and data, and stores the data at the pointer. Pointer 0x00 drives `ctrl_o[7:0]` and 0x01 drives `ctrl_o[15:8]`. Both keep their value until they are written again.
- R5: Pointers 0x04/0x05 are the low and high bytes of `thr_lo_o`. Pointers 0x06/0x07 are the low and high bytes of `thr_hi_o`.
- R6: Writes to 0x02, 0x03 and to any pointer of 0x08 or above are acknowledged and discarded. A read at 0x08 or above returns 0x00.
- R7: A read is address+W, pointer, repeated START, address+R. The block then sends the byte at the pointer, MSB first. Pointer 0x02 returns `meas_i[7:0]` and 0x03 returns `meas_i[15:8]`. Other readable pointers return the stored value.
- R8: Each transaction carries a single data byte. A second write byte is neither acknowledged nor stored. After the read byte the block releases SDA whatever the master answers, and further clocks read 0xFF.
- R9: After an address mismatch the block keeps SDA released until the next START or STOP, even if a later byte carries its own address.
- R10: A STOP or START that arrives in the middle of a byte returns the block to idle, and no register is updated.
- R11: Reset clears every stored register to 0x00 and releases SDA.
- R12: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| meas_i | input | 16 | Measurement bytes; [7:0] at 0x02, [15:8] at 0x03 |
| ctrl_o | output | 16 | Command bytes; [7:0] from 0x00, [15:8] from 0x01 |
| thr_lo_o | output | 16 | Low limit from 0x04 (low byte) and 0x05 |
| thr_hi_o | output | 16 | High limit from 0x06 (low byte) and 0x07 |

## Verification
The bench sweeps all 128 address values. A design that compared the R/W bit or decoded too few bits would acknowledge foreign addresses, and one that kept listening after a mismatch would acknowledge a later byte that looks like its own address. Writes and reads run over pointers 0x00 to 0x09 under two measurement patterns. A design that stored into the sensor bytes, or aliased pointers above the map, would show wrong read-back or disturbed outputs. Transactions are also cut off by STOP and by repeated START after a partial byte, and a design that committed the half-shifted byte would alter a register. A second write byte and extra read clocks are also sent, which catches a design that keeps driving or keeps storing past one byte.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_PTR,
    ST_ACK_PTR,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int RO_FIRST = 2,
  parameter int RO_COUNT = 2,
  localparam int PTR_BITS = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                ptr,
  input  logic [7:0]                wr_data,
  input  logic [RO_COUNT*8-1:0]     meas_i,
  output logic [7:0]                rd_data,
  output logic [NUM_REGS*8-1:0]     regs_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g >= RO_FIRST && g < RO_FIRST + RO_COUNT) begin : g_ro
      assign regs_flat[g*8 +: 8] = meas_i[(g-RO_FIRST)*8 +: 8];
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs_flat[g*8 +: 8] <= '0;
        else if (wr_en && int'(ptr) == g)
          regs_flat[g*8 +: 8] <= wr_data;
      end
    end
  end

  always_comb begin
    if (int'(ptr) < NUM_REGS)
      rd_data = regs_flat[{ptr[PTR_BITS-1:0], 3'b000} +: 8];
    else
      rd_data = '0;
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_regmap_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] ptr,
  output tgt_state_e state
);
  logic [BYTE_W-1:0] shreg;
  logic [3:0]        bitcnt;
  logic              rw;
  logic              byte_full;

  assign byte_full = (bitcnt == 4'd8);
  assign wr_data   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      rw     <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise && !byte_full) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && byte_full) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ACK_ADDR;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_PTR) begin
                ptr    <= shreg;
                sda_oe <= 1'b1;
                state  <= ST_ACK_PTR;
              end else begin
                wr_en  <= 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_ACK_WDATA;
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_fall) begin
              if (rw) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                bitcnt <= 4'd1;
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_PTR;
              end
            end
          end
          ST_ACK_PTR: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_ACK_WDATA: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_IGNORE;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (!byte_full) begin
                sda_oe <= ~shreg[6];
                shreg  <= {shreg[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
  import i2c_regmap_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_REGS    = 8,
  parameter int         RO_FIRST    = 2,
  parameter int         RO_COUNT    = 2,
  parameter int         CTRL_BASE   = 0,
  parameter int         THR_LO_BASE = 4,
  parameter int         THR_HI_BASE = 6,
  localparam int        MEAS_W      = RO_COUNT * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [MEAS_W-1:0] meas_i,
  output logic [15:0]       ctrl_o,
  output logic [15:0]       thr_lo_o,
  output logic [15:0]       thr_hi_o
);
  logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic        wr_en;
  logic [7:0]  wr_data, ptr, rd_data;
  logic [NUM_REGS*BYTE_W-1:0] regs_flat;
  tgt_state_e  state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_data(wr_data),
    .ptr(ptr), .state(state)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .RO_FIRST(RO_FIRST), .RO_COUNT(RO_COUNT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
    .meas_i(meas_i), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  assign ctrl_o   = regs_flat[CTRL_BASE*BYTE_W   +: 16];
  assign thr_lo_o = regs_flat[THR_LO_BASE*BYTE_W +: 16];
  assign thr_hi_o = regs_flat[THR_HI_BASE*BYTE_W +: 16];
endmodule

// File: rtl/i2c_regmap_chk.sv
module i2c_regmap_chk
  import i2c_regmap_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_oe,
  input logic        wr_en,
  input tgt_state_e  state,
  input logic [15:0] ctrl_o,
  input logic [15:0] thr_lo_o,
  input logic [15:0] thr_hi_o
);
  // R12
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_s |=> $stable(sda_oe));

  // R3
  addr_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK_ADDR) |-> sda_oe);

  // R9
  ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe);

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_o));

  // R5
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({thr_hi_o, thr_lo_o}));
endmodule

bind i2c_regmap_target i2c_regmap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .wr_en(wr_en),
  .state(state), .ctrl_o(ctrl_o), .thr_lo_o(thr_lo_o), .thr_hi_o(thr_hi_o)
);

// File: tb/sim_i2c_regmap_target.sv
module sim_i2c_regmap_target;
  localparam int Q = 6;
  localparam logic [6:0] MY_ADDR = 7'b1000100;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        m_scl = 1'b1;
  logic        m_low = 1'b0;
  logic        sda_oe;
  logic [15:0] meas, ctrl, thr_lo, thr_hi;
  wire         sda_bus = ~(m_low | sda_oe);

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int oe_hi_change = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [0:7];

  i2c_regmap_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .meas_i(meas), .ctrl_o(ctrl), .thr_lo_o(thr_lo), .thr_hi_o(thr_hi)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errs = errs + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // R12 monitor on the raw master clock
  always @(negedge clk) begin
    if (rst_n === 1'b1 && m_scl && sda_oe !== prev_oe) oe_hi_change++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; m_scl = 1'b1; wq(Q);
    m_low = 1'b1; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    m_low = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_low = 1'b1; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_low = 1'b0; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; wq(Q);
      m_scl = 1'b1; wq(2*Q);
      m_scl = 1'b0; wq(Q);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    ack = ~sda_bus; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic rd_byte(output logic [7:0] d, input bit nack, output bit drv);
    d = '0;
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wq(Q); m_scl = 1'b1; wq(Q);
      d = {d[6:0], sda_bus};
      wq(Q); m_scl = 1'b0;
    end
    wq(Q);
    m_low = ~nack; wq(Q);
    m_scl = 1'b1; wq(Q);
    drv = sda_oe; wq(Q);
    m_scl = 1'b0; wq(Q);
    m_low = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] p, input logic [7:0] d, output bit a0, output bit a1, output bit a2);
    bus_start();
    wr_byte({MY_ADDR, 1'b0}, a0);
    wr_byte(p, a1);
    wr_byte(d, a2);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] p, output logic [7:0] d, output bit acks, output bit drv);
    bit a0, a1, a2;
    bus_start();
    wr_byte({MY_ADDR, 1'b0}, a0);
    wr_byte(p, a1);
    bus_rstart();
    wr_byte({MY_ADDR, 1'b1}, a2);
    rd_byte(d, 1'b1, drv);
    bus_stop();
    acks = a0 & a1 & a2;
  endtask

  function automatic logic [7:0] expect_rd(input int p);
    if (p >= 8) return 8'h00;
    if (p == 2) return meas[7:0];
    if (p == 3) return meas[15:8];
    return model[p];
  endfunction

  task automatic check_outputs(input string tag);
    chk(tag, "ctrl_o", {16'h0, ctrl}, {16'h0, model[1], model[0]});
    chk(tag, "thr_lo_o", {16'h0, thr_lo}, {16'h0, model[5], model[4]});
    chk(tag, "thr_hi_o", {16'h0, thr_hi}, {16'h0, model[7], model[6]});
  endtask

  initial begin
    bit a0, a1, a2, drv;
    logic [7:0] d;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    meas = 16'hA55A;
    rst_n = 1'b0;
    wq(5);
    // R11 reset state
    chk("R11", "sda_oe at reset", {31'h0, sda_oe}, 32'h0);
    rst_n = 1'b1;
    wq(5);
    check_outputs("R11");

    // R4 R5 R6: write sweep over pointers 0..9
    for (int p = 0; p < 10; p++) begin
      logic [7:0] val;
      val = 8'((p * 29 + 7) ^ 8'h5A);
      do_write(8'(p), val, a0, a1, a2);
      chk("R3", $sformatf("acks on write ptr %0d", p), {29'h0, a0, a1, a2}, 32'h7);
      if (p < 8 && p != 2 && p != 3) model[p] = val;
      check_outputs(p == 2 || p == 3 || p >= 8 ? "R6" : (p >= 4 ? "R5" : "R4"));
    end

    // R7 R6: read sweep under two measurement patterns
    for (int k = 0; k < 2; k++) begin
      meas = (k == 0) ? 16'hA55A : 16'h3C81;
      for (int p = 0; p < 10; p++) begin
        do_read(8'(p), d, a0, drv);
        chk("R7", $sformatf("read acks ptr %0d", p), {31'h0, a0}, 32'h1);
        chk(p >= 8 ? "R6" : "R7", $sformatf("read data ptr %0d", p), {24'h0, d}, {24'h0, expect_rd(p)});
        chk("R8", "released after read byte", {31'h0, drv}, 32'h0);
      end
    end

    // R1 R9: address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start();
      wr_byte({7'(a), 1'b0}, a0);
      chk("R1", $sformatf("ack for addr %02h", a), {31'h0, a0}, {31'h0, (a == int'(MY_ADDR))});
      if (a != int'(MY_ADDR)) begin
        wr_byte({MY_ADDR, 1'b0}, a1);
        chk("R9", $sformatf("no ack after mismatch %02h", a), {31'h0, a1}, 32'h0);
      end
      bus_stop();
    end
    check_outputs("R9");

    // R2: byte without START
    wr_byte({MY_ADDR, 1'b0}, a0);
    chk("R2", "no ack without START", {31'h0, a0}, 32'h0);
    bus_stop();

    // R8: second write byte refused
    bus_start();
    wr_byte({MY_ADDR, 1'b0}, a0);
    wr_byte(8'h00, a1);
    wr_byte(8'h3C, a2);
    chk("R3", "first data byte ack", {31'h0, a2}, 32'h1);
    wr_byte(8'hC3, a2);
    chk("R8", "second data byte ack", {31'h0, a2}, 32'h0);
    bus_stop();
    model[0] = 8'h3C;
    check_outputs("R8");

    // R8: master ACKs the read byte, then more clocks return 0xFF
    bus_start();
    wr_byte({MY_ADDR, 1'b0}, a0);
    wr_byte(8'h06, a1);
    bus_rstart();
    wr_byte({MY_ADDR, 1'b1}, a2);
    rd_byte(d, 1'b0, drv);
    chk("R7", "read before master ack", {24'h0, d}, {24'h0, model[6]});
    rd_byte(d, 1'b1, drv);
    chk("R8", "extra read clocks", {24'h0, d}, 32'hFF);
    bus_stop();

    // R10: STOP in the middle of a data byte
    bus_start();
    wr_byte({MY_ADDR, 1'b0}, a0);
    wr_byte(8'h01, a1);
    send_bits(8'hA5, 4);
    bus_stop();
    check_outputs("R10");

    // R10 R2: repeated START mid-byte, then a full write
    bus_start();
    wr_byte({MY_ADDR, 1'b0}, a0);
    wr_byte(8'h06, a1);
    send_bits(8'h11, 3);
    bus_rstart();
    wr_byte({MY_ADDR, 1'b0}, a0);
    wr_byte(8'h07, a1);
    wr_byte(8'h99, a2);
    bus_stop();
    chk("R2", "write after repeated START acked", {29'h0, a0, a1, a2}, 32'h7);
    model[7] = 8'h99;
    check_outputs("R10");

    // R12
    chk("R12", "sda_oe changes while SCL high", oe_hi_change, 32'h0);

    // R11: reset in mid-life clears registers
    rst_n = 1'b0;
    wq(3);
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    check_outputs("R11");
    rst_n = 1'b1;
    wq(3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule